// File: doc/BRIEF.md
# Real-Time Memory Slot Arbiter

The arbiter picks at most one winner among a set of memory clients each time a DRAM slot is offered. The lowest-numbered clients are real-time clients. They are served at a fixed-priority level in which a smaller index wins. After a real-time client wins at that level, a block-out counter stops it from winning there again until a programmed number of slots has passed. This keeps a real-time client from taking more than its share of fixed-priority service.

All other requests go to a round-robin level that sits below the fixed-priority level. These are the requests of the non-real-time clients and the requests of real-time clients that are still blocked. The round-robin level takes every offered slot that no eligible fixed-priority request claims, so an offered slot is never left unused while a request is pending. Each grant is reported with a flag that tells which level produced it. The DRAM command sequencer, the data paths and the bus protocol are handled elsewhere.

Top module: `mem_slot_arbiter`

## Requirements
- R1: `gnt_o` is zero or one-hot. It is nonzero only while `slot_i` is high, and it only grants a client whose `req_i` bit is set. It is all zeros when no client requests.
- R2: When `slot_i` is high and any `req_i` bit is set, exactly one grant is issued.
- R3: Clients 0 to `N_RT-1` are real-time. Among the real-time clients that are requesting and not blocked, the lowest index wins at the fixed-priority level. Any such request beats every round-robin candidate.
- R4: A fixed-priority grant to a real-time client loads its counter with that client's interval K, taken from `blk_ival_i[i*CNT_W +: CNT_W]`. With K > 0, the client cannot win at the fixed-priority level in the next K offered slots. It is eligible again in the slot after those K slots.
- R5: A real-time client that requests while blocked is still served, through the round-robin level, in a slot where no unblocked real-time client requests.
- R6: A real-time client whose interval is 0 is never blocked. It can win at the fixed-priority level in consecutive slots.
- R7: The round-robin winner is the first requesting client at or after the pointer, wrapping from `N_CLIENTS-1` to 0. After a round-robin grant the pointer moves to the winner's index plus one, with wrap. The pointer does not move on fixed-priority grants or in cycles without a grant.
- R8: `fp_lvl_o` is 1 when the grant in that cycle came from the fixed-priority level. It is 0 for a round-robin grant and when there is no grant.
- R9: Block-out counters count down only in cycles where `slot_i` is high. Cycles without an offered slot do not shorten a block-out.
- R10: Reset clears every block-out counter and sets the round-robin pointer to client 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | A DRAM slot is offered in this cycle |
| req_i | input | N_CLIENTS | Request line per client |
| blk_ival_i | input | N_RT*CNT_W | Block-out interval per real-time client, in slots |
| gnt_o | output | N_CLIENTS | One-hot grant, valid in the same cycle as `slot_i` |
| fp_lvl_o | output | 1 | 1 when the grant came from the fixed-priority level |

## Verification
The stimulus is built so that each case separates two behaviours that could be confused:
- All clients requesting at once separates fixed priority from rotation.
- A real-time client that requests alone just after its own grant separates the fixed-priority level from the round-robin fallback.
- Runs of cycles with no offered slot between grants separate counters that age only on offered slots from counters that age every cycle.
- Rotating patterns of non-real-time requests show that the pointer moves only on round-robin grants.
- A zero interval, a change of intervals during the run and a reset during traffic show how counter loading and clearing work.
- A pseudo-random run that mixes all clients and drops slots at random checks the work-conserving rule against an independent model.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;

   // service level reported with each grant
   typedef enum logic {
      LVL_RR = 1'b0,
      LVL_FP = 1'b1
   } svc_lvl_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/mem_arb_bocnt.sv
module mem_arb_bocnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] ival_i,
   output logic             blocked_o
);

   logic [CNT_W-1:0] cnt_q;

   // the counter ages only on offered slots; a load wins over aging
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (slot_i) begin
         if (load_i)
            cnt_q <= ival_i;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign blocked_o = (cnt_q != '0);

endmodule

// File: rtl/mem_arb_fp_pick.sv
module mem_arb_fp_pick #(
   parameter int N_RT = 3
) (
   input  logic [N_RT-1:0] elig_i,
   output logic [N_RT-1:0] gnt_o,
   output logic            any_o
);

   // isolate the lowest set bit: lowest index wins
   assign gnt_o = elig_i & (~elig_i + 1'b1);
   assign any_o = |elig_i;

endmodule

// File: rtl/mem_arb_rr_pick.sv
module mem_arb_rr_pick #(
   parameter int N_CLIENTS = 6,
   parameter int PTR_W     = 3
) (
   input  logic [N_CLIENTS-1:0] req_i,
   input  logic [PTR_W-1:0]     ptr_i,
   output logic [N_CLIENTS-1:0] gnt_o,
   output logic [PTR_W-1:0]     idx_o,
   output logic                 any_o
);

   localparam int SUM_W = PTR_W + 1;

   logic [SUM_W-1:0] pos;
   logic             found;

   // scan from the pointer upward, wrapping once
   always_comb begin
      gnt_o = '0;
      idx_o = '0;
      found = 1'b0;
      pos   = '0;
      for (int k = 0; k < N_CLIENTS; k++) begin
         pos = {1'b0, ptr_i} + SUM_W'(k);
         if (pos >= SUM_W'(N_CLIENTS))
            pos = pos - SUM_W'(N_CLIENTS);
         if (!found && req_i[pos[PTR_W-1:0]]) begin
            found                  = 1'b1;
            gnt_o[pos[PTR_W-1:0]]  = 1'b1;
            idx_o                  = pos[PTR_W-1:0];
         end
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter
   import mem_arb_pkg::*;
#(
   parameter int N_CLIENTS = 6,
   parameter int N_RT      = 3,
   parameter int CNT_W     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    slot_i,
   input  logic [N_CLIENTS-1:0]    req_i,
   input  logic [N_RT*CNT_W-1:0]   blk_ival_i,
   output logic [N_CLIENTS-1:0]    gnt_o,
   output logic                    fp_lvl_o
);

   localparam int PTR_W = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;

   initial begin : p_param_chk
      assert (N_CLIENTS >= 2) else $error("N_CLIENTS must be at least 2");
      assert (N_RT >= 1 && N_RT <= N_CLIENTS) else $error("N_RT out of range");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
   end

   logic [N_RT-1:0]      rt_blocked;
   logic [N_RT-1:0]      rt_elig;
   logic [N_RT-1:0]      fp_gnt;
   logic                 fp_any;
   logic [N_CLIENTS-1:0] rr_gnt;
   logic [PTR_W-1:0]     rr_idx;
   logic [PTR_W-1:0]     rr_nxt;
   logic                 rr_any;
   logic [PTR_W-1:0]     rr_ptr_q;
   svc_lvl_e             lvl;

   // one block-out counter per real-time client
   for (genvar i = 0; i < N_RT; i++) begin : g_rt
      mem_arb_bocnt #(.CNT_W(CNT_W)) u_bocnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .slot_i    (slot_i),
         .load_i    (fp_gnt[i] & fp_any),
         .ival_i    (blk_ival_i[i*CNT_W +: CNT_W]),
         .blocked_o (rt_blocked[i])
      );
   end

   assign rt_elig = req_i[N_RT-1:0] & ~rt_blocked;

   mem_arb_fp_pick #(.N_RT(N_RT)) u_fp (
      .elig_i (rt_elig),
      .gnt_o  (fp_gnt),
      .any_o  (fp_any)
   );

   // the pool is every request: unblocked real-time ones already won above
   mem_arb_rr_pick #(.N_CLIENTS(N_CLIENTS), .PTR_W(PTR_W)) u_rr (
      .req_i (req_i),
      .ptr_i (rr_ptr_q),
      .gnt_o (rr_gnt),
      .idx_o (rr_idx),
      .any_o (rr_any)
   );

   // pointer successor: a power-of-two client count wraps for free
   if (is_pow2(N_CLIENTS)) begin : g_wrap_free
      assign rr_nxt = rr_idx + 1'b1;
   end else begin : g_wrap_cmp
      assign rr_nxt = (rr_idx == PTR_W'(N_CLIENTS - 1)) ? '0 : rr_idx + 1'b1;
   end

   always_comb begin
      gnt_o = '0;
      lvl   = LVL_RR;
      if (slot_i) begin
         if (fp_any) begin
            gnt_o[N_RT-1:0] = fp_gnt;
            lvl             = LVL_FP;
         end else begin
            gnt_o = rr_gnt;
         end
      end
   end

   assign fp_lvl_o = (lvl == LVL_FP);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_ptr_q <= '0;
      else if (slot_i && !fp_any && rr_any)
         rr_ptr_q <= rr_nxt;
   end

endmodule

// File: rtl/mem_slot_arbiter_chk.sv
module mem_slot_arbiter_chk #(
   parameter int N_CLIENTS = 6,
   parameter int N_RT      = 3,
   parameter int CNT_W     = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  slot_i,
   input logic [N_CLIENTS-1:0]  req_i,
   input logic [N_RT*CNT_W-1:0] blk_ival_i,
   input logic [N_CLIENTS-1:0]  gnt_o,
   input logic                  fp_lvl_o
);

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   assert_no_slot_no_gnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_i |-> (gnt_o == '0));

   assert_gnt_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);

   assert_work_conserving_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && (req_i != '0)) |-> (gnt_o != '0));

   assert_fp_level_rt_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fp_lvl_o |-> ((gnt_o >> N_RT) == '0 && gnt_o != '0));

   for (genvar i = 0; i < N_RT; i++) begin : g_bo
      // R4: a nonzero interval forbids a back-to-back fixed-priority win
      assert_blockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (fp_lvl_o && gnt_o[i] && blk_ival_i[i*CNT_W +: CNT_W] != '0)
         |=> !(fp_lvl_o && gnt_o[i]));
   end

endmodule

bind mem_slot_arbiter mem_slot_arbiter_chk #(
   .N_CLIENTS (N_CLIENTS),
   .N_RT      (N_RT),
   .CNT_W     (CNT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot_i     (slot_i),
   .req_i      (req_i),
   .blk_ival_i (blk_ival_i),
   .gnt_o      (gnt_o),
   .fp_lvl_o   (fp_lvl_o)
);

// File: tb/test_mem_slot_arbiter.sv
`timescale 1ns/1ps
module test_mem_slot_arbiter;

   localparam int N  = 6;
   localparam int NR = 3;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot = 1'b0;
   logic [N-1:0]  req = '0;
   logic [NR*CW-1:0] ival = '0;
   logic [N-1:0]  gnt;
   logic          lvl;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [N-1:0] g;
      logic         l;
      string        tag;
   } exp_t;
   exp_t q[$];

   // reference model state
   int m_cnt[NR];
   int m_ptr;

   always #2.5 clk = ~clk;

   mem_slot_arbiter #(.N_CLIENTS(N), .N_RT(NR), .CNT_W(CW)) i_mem_slot_arbiter (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_i     (slot),
      .req_i      (req),
      .blk_ival_i (ival),
      .gnt_o      (gnt),
      .fp_lvl_o   (lvl)
   );

   task automatic model_reset();
      for (int i = 0; i < NR; i++) m_cnt[i] = 0;
      m_ptr = 0;
   endtask

   // driver: apply one cycle and push the expected outcome
   task automatic cyc(input logic s, input logic [N-1:0] r, input string tag);
      exp_t e;
      int   fp;
      int   rw;
      @(negedge clk);
      slot = s;
      req  = r;
      fp = -1;
      rw = -1;
      e.g = '0;
      e.l = 1'b0;
      e.tag = tag;
      for (int i = NR - 1; i >= 0; i--)
         if (r[i] && m_cnt[i] == 0) fp = i;
      if (s) begin
         if (fp >= 0) begin
            e.g[fp] = 1'b1;
            e.l     = 1'b1;
         end else begin
            for (int k = N - 1; k >= 0; k--)
               if (r[(m_ptr + k) % N]) rw = (m_ptr + k) % N;
            if (rw >= 0) e.g[rw] = 1'b1;
         end
      end
      q.push_back(e);
      if (s) begin
         for (int i = 0; i < NR; i++) begin
            if (i == fp) m_cnt[i] = int'(ival[i*CW +: CW]);
            else if (m_cnt[i] > 0) m_cnt[i]--;
         end
         if (rw >= 0) m_ptr = (rw + 1) % N;
      end
   endtask

   // monitor: compare just before the next rising edge
   always begin
      exp_t e;
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
         e = q.pop_front();
         n_chk++;
         if (gnt !== e.g || lvl !== e.l) begin
            n_bad++;
            $display("FAIL %s: gnt=%b lvl=%b expected gnt=%b lvl=%b",
                     e.tag, gnt, lvl, e.g, e.l);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      slot  = 1'b0;
      req   = '0;
      repeat (2) @(negedge clk);
      #2;
      n_chk++;
      if (gnt !== '0 || lvl !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: gnt=%b lvl=%b expected gnt=%b lvl=0 in reset", gnt, lvl, {N{1'b0}});
      end
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      logic [15:0] lf;
      model_reset();
      ival = {4'd3, 4'd0, 4'd2};   // client2=3, client1=0, client0=2
      do_reset();

      // R10: pointer at 0, counters clear
      cyc(1'b1, 6'b111000, "R10");
      do_reset();
      cyc(1'b1, 6'b000111, "R10");
      do_reset();

      // R1 idle and no-slot cases
      cyc(1'b0, 6'b111111, "R1");
      cyc(1'b1, 6'b000000, "R1");

      // R3 / R6 / R4 fixed priority and block-out
      cyc(1'b1, 6'b111111, "R3");
      cyc(1'b1, 6'b111111, "R6");
      cyc(1'b1, 6'b000110, "R6");
      cyc(1'b1, 6'b000101, "R4");
      cyc(1'b1, 6'b000001, "R4");
      cyc(1'b1, 6'b000101, "R3");

      // R9 / R5: no-slot cycles do not age the counter
      cyc(1'b1, 6'b000001, "R4");
      cyc(1'b0, 6'b000001, "R9");
      cyc(1'b0, 6'b000001, "R9");
      cyc(1'b0, 6'b000001, "R9");
      cyc(1'b1, 6'b000001, "R5");
      cyc(1'b1, 6'b001001, "R5");

      // R7 rotation among non-real-time clients
      cyc(1'b1, 6'b111000, "R7");
      cyc(1'b1, 6'b111000, "R7");
      cyc(1'b1, 6'b101000, "R7");
      cyc(1'b0, 6'b101000, "R7");
      cyc(1'b1, 6'b101000, "R7");
      cyc(1'b1, 6'b111010, "R7");
      cyc(1'b1, 6'b111000, "R8");

      // R2 pseudo-random mixed traffic, intervals changed midway
      lf = 16'hACE1;
      for (int n = 0; n < 160; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (n == 80) ival = {4'd1, 4'd2, 4'd0};
         cyc(lf[7:6] != 2'b00, lf[5:0], "R2");
      end

      // R10 reset in the middle of traffic
      cyc(1'b1, 6'b000111, "R4");
      do_reset();
      cyc(1'b1, 6'b000111, "R10");
      cyc(1'b1, 6'b111000, "R10");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule